// File: doc/BRIEF.md
# Running-Disparity Lane Inversion Encoder

This block sits on one serial lane ahead of the serializer and balances the line over time. On each clock where it is enabled, it takes a six-bit word and works out its disparity. It then sends the word either as it is or with every bit flipped. A flag bit tells the far end which choice was made. A small signed running-disparity register records the accumulated imbalance. It steers the next choice and is clamped to an asymmetric window.

The data disparity is the number of ones minus the number of zeros in the word, so it is always even and lies between -6 and +6. The inversion rule treats a running disparity of exactly zero as its own case. In that case the word is always flipped. A wide link uses eight instances, one per lane.

Top module: `dcbal_lane`

## Requirements
- R1: A synchronous active-high reset clears the output word, the flag and the running disparity to zero on the next clock edge.
- R2: When the running disparity is exactly zero, an accepted word is always sent inverted, whatever its disparity.
- R3: When the running disparity is positive, a word with more ones than zeros is sent inverted. A word with as many or fewer ones is sent unmodified.
- R4: When the running disparity is negative, a word with more ones than zeros is sent unmodified. A word with as many or fewer ones is sent inverted.
- R5: The flag output is 1 when the output word is the bitwise inverse of the accepted input, and 0 when the output equals the input.
- R6: After each accepted word, the running disparity changes by (data disparity - 1) if the word was sent unmodified. It changes by (1 - data disparity) if the word was inverted.
- R7: The running disparity is a signed 4-bit two's-complement value on `rd_o` and is clamped to the range -6 to +7.
- R8: While `en` is low, the output word, the flag and the running disparity hold their values.
- R9: The output word, flag and running disparity for a word presented with `en` high appear after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accept `din` on this edge |
| din | input | 6 | Data word to encode |
| dout | output | 6 | Encoded word, plain or inverted |
| bal_o | output | 1 | 1 = word inverted, 0 = unmodified |
| rd_o | output | 4 | Running disparity, signed two's complement |

## Verification
The properties assume that `din` is a defined value whenever `en` is high. They also assume that reset is applied before the first accepted word, so that the running disparity always starts from zero. The stimulus drives every input on the falling edge and only after reset has been asserted. It walks a word sequence that takes the running disparity through zero, positive and negative values. The sequence reaches both the +7 and the -6 limits.

// File: rtl/dcbal_pkg.sv
package dcbal_pkg;
  localparam int WORD_W = 6;
  localparam int RD_W   = 4;
  localparam int RD_HI  = 7;
  localparam int RD_LO  = -6;
endpackage

// File: rtl/dcbal_disparity.sv
module dcbal_disparity #(
  parameter int W  = 6,
  parameter int DW = 5
) (
  input  logic [W-1:0]         word,
  output logic signed [DW-1:0] disp
);
  always_comb begin
    int ones;
    ones = 0;
    for (int i = 0; i < W; i++) ones += int'(word[i]);
    disp = DW'(2 * ones - W);
  end
endmodule

// File: rtl/dcbal_decide.sv
module dcbal_decide #(
  parameter int RD_W = 4,
  parameter int DW   = 5
) (
  input  logic signed [RD_W-1:0] rd,
  input  logic signed [DW-1:0]   disp,
  output logic                   inv,
  output logic signed [DW:0]     delta
);
  logic rd_zero, rd_pos, dd_pos;

  always_comb begin
    rd_zero = (rd == '0);
    rd_pos  = !rd[RD_W-1] && !rd_zero;
    dd_pos  = (disp > 0);
    if (rd_zero)     inv = 1'b1;
    else if (rd_pos) inv = dd_pos;
    else             inv = !dd_pos;
    if (inv) delta = (DW+1)'(1 - int'(disp));
    else     delta = (DW+1)'(int'(disp) - 1);
  end
endmodule

// File: rtl/dcbal_accum.sv
module dcbal_accum #(
  parameter int RD_W = 4,
  parameter int DW   = 5,
  parameter int HI   = 7,
  parameter int LO   = -6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [DW:0]     delta,
  output logic signed [RD_W-1:0] rd_q
);
  logic signed [RD_W-1:0] rd_nxt;

  always_comb begin
    int sum;
    sum = int'(rd_q) + int'(delta);
    if (sum > HI)      sum = HI;
    else if (sum < LO) sum = LO;
    rd_nxt = RD_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (en) rd_q <= rd_nxt;
  end
endmodule

// File: rtl/dcbal_lane.sv
module dcbal_lane
  import dcbal_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int RDW   = RD_W,
  parameter int SAT_H = RD_HI,
  parameter int SAT_L = RD_LO
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic           bal_o,
  output logic [RDW-1:0] rd_o
);
  localparam int DW = $clog2(W + 1) + 2;

  logic signed [DW-1:0]  disp;
  logic signed [DW:0]    delta;
  logic signed [RDW-1:0] rd_q;
  logic                  inv;

  dcbal_disparity #(.W(W), .DW(DW)) u_disp (
    .word (din),
    .disp (disp)
  );

  dcbal_decide #(.RD_W(RDW), .DW(DW)) u_dec (
    .rd    (rd_q),
    .disp  (disp),
    .inv   (inv),
    .delta (delta)
  );

  dcbal_accum #(.RD_W(RDW), .DW(DW), .HI(SAT_H), .LO(SAT_L)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .delta (delta),
    .rd_q  (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      bal_o <= 1'b0;
    end else if (en) begin
      dout  <= inv ? ~din : din;
      bal_o <= inv;
    end
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/dcbal_lane_chk.sv
module dcbal_lane_chk #(
  parameter int W     = 6,
  parameter int RDW   = 4,
  parameter int SAT_H = 7,
  parameter int SAT_L = -6
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [W-1:0]   din,
  input logic [W-1:0]   dout,
  input logic           bal_o,
  input logic [RDW-1:0] rd_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dout == '0 && !bal_o && rd_o == '0));

  a_r2_zero_inverts: assert property (@(posedge clk) disable iff (rst)
    (en && rd_o == '0) |=> bal_o);

  a_r3_pos_rule: assert property (@(posedge clk) disable iff (rst)
    (en && !rd_o[RDW-1] && rd_o != '0) |=> (bal_o == ($countones($past(din)) * 2 > W)));

  a_r4_neg_rule: assert property (@(posedge clk) disable iff (rst)
    (en && rd_o[RDW-1]) |=> (bal_o == ($countones($past(din)) * 2 <= W)));

  a_r5_flag_matches: assert property (@(posedge clk) disable iff (rst)
    en |=> (bal_o == (dout != $past(din))));

  a_r6_rd_moves: assert property (@(posedge clk) disable iff (rst)
    en |=> (rd_o != $past(rd_o)));

  a_r7_rd_window: assert property (@(posedge clk) disable iff (rst)
    ($signed(rd_o) <= SAT_H && $signed(rd_o) >= SAT_L));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(bal_o) && $stable(rd_o)));
endmodule

bind dcbal_lane dcbal_lane_chk #(.W(W), .RDW(RDW), .SAT_H(SAT_H), .SAT_L(SAT_L)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .din   (din),
  .dout  (dout),
  .bal_o (bal_o),
  .rd_o  (rd_o)
);

// File: tb/test_dcbal_lane.sv
module test_dcbal_lane;
  localparam time CLK_P = 5ns;
  localparam int  NV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [5:0] din = '0;
  logic [5:0] dout;
  logic       bal_o;
  logic [3:0] rd_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  dcbal_lane i_dcbal_lane (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .dout(dout), .bal_o(bal_o), .rd_o(rd_o)
  );

  // {din, expected dout, expected flag, expected rd}, starting from rd = 0
  localparam logic [16:0] VEC [NV] = '{
    {6'b000000, 6'b111111, 1'b1, 4'b0111},  // rd 0 -> +7 (upper limit)
    {6'b111111, 6'b000000, 1'b1, 4'b0010},
    {6'b000111, 6'b000111, 1'b0, 4'b0001},
    {6'b000011, 6'b000011, 1'b0, 4'b1110},
    {6'b001111, 6'b001111, 1'b0, 4'b1111},
    {6'b000001, 6'b111110, 1'b1, 4'b0100},
    {6'b111111, 6'b000000, 1'b1, 4'b1111},
    {6'b111111, 6'b111111, 1'b0, 4'b0100},
    {6'b000000, 6'b000000, 1'b0, 4'b1101},
    {6'b000000, 6'b111111, 1'b1, 4'b0100},
    {6'b000000, 6'b000000, 1'b0, 4'b1101},
    {6'b010101, 6'b101010, 1'b1, 4'b1110},
    {6'b110111, 6'b110111, 1'b0, 4'b0001},
    {6'b000000, 6'b000000, 1'b0, 4'b1010},  // reaches -6 (lower limit)
    {6'b100000, 6'b011111, 1'b1, 4'b1111},
    {6'b011111, 6'b011111, 1'b0, 4'b0010}
  };

  task automatic check(string req, logic [5:0] eo, logic ef, logic [3:0] er);
    checks++;
    if (dout !== eo || bal_o !== ef || rd_o !== er) begin
      errors++;
      $display("FAIL %s: got dout=%b flag=%b rd=%0d, expected dout=%b flag=%b rd=%0d",
               req, dout, bal_o, $signed(rd_o), eo, ef, $signed(er));
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 6'b0, 1'b0, 4'b0);
    rst = 1'b0;
    // table walk covers R2..R7 and R9 (result one edge later)
    for (int i = 0; i < NV; i++) begin
      din = VEC[i][16:11];
      en  = 1'b1;
      @(negedge clk);
      check($sformatf("R3/R4/R5/R6/R7/R9 vec %0d", i), VEC[i][10:5], VEC[i][4], VEC[i][3:0]);
    end
    // R8: enable low holds everything
    en  = 1'b0;
    din = 6'b000000;
    repeat (3) @(negedge clk);
    check("R8 hold", 6'b011111, 1'b0, 4'b0010);
    // R9: single accepted word after idle, rd +2 -> -5
    en = 1'b1;
    @(negedge clk);
    check("R9 latency", 6'b000000, 1'b0, 4'b1011);
    // R1: reset mid-run
    en  = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 6'b0, 1'b0, 4'b0);
    rst = 1'b0;
    // R2: zero running disparity inverts a positive word
    din = 6'b111111;
    en  = 1'b1;
    @(negedge clk);
    check("R2 zero rd inverts", 6'b000000, 1'b1, 4'b1011);
    en = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule